// File: doc/BRIEF.md
# Nested Interrupt Acknowledge and Completion Tracker

This block is the per-processor side of an interrupt controller that decides what a processor is currently servicing. An external selector offers the highest pending interrupt ID and its priority. When the processor acknowledges, the tracker accepts that interrupt only if it preempts the current work. It then records the interrupt that was running before it, makes the new one running, and asks the pending logic to clear the interrupt's pending state.

Each interrupt has a back-link that names the interrupt it preempted. Completions need not follow acknowledge order. Completing the running interrupt restores its back-link. Completing an interrupt buried deeper in the preemption history removes it from the chain by walking the links, one link per clock, while a busy flag holds off new requests. After a level-sensitive interrupt completes, the block can request that it be marked pending again.

A lower priority value is more urgent. A running priority of `0x100` means that nothing is running, and the ID value 1023 means "none".

Top module: `nest_irq_tracker`

## Requirements
- R1: After reset, `run_id` is 1023, `run_prio` is 0x100, `busy` is low, every back-link holds 1023 and the strobes `ack_valid`, `clr_valid` and `rep_valid` are low.
- R2: An accepted acknowledge request is rejected when `hp_id` is 1023 or not below `NUM_IRQ`, or when `{1'b0,hp_prio}` is not strictly below `run_prio`. One cycle later `ack_valid` pulses with `ack_id` = 1023, `clr_valid` stays low, and `run_id` and `run_prio` do not change.
- R3: A successful acknowledge stores the old `run_id` as the back-link of `hp_id`. One cycle after the request, `ack_valid` pulses with `ack_id` = `hp_id`, `run_id` becomes `hp_id` and `run_prio` becomes `hp_prio`.
- R4: With a successful acknowledge, `clr_valid` pulses in the same cycle as `ack_valid`, with `clr_id` = `hp_id`. `clr_all` equals bit `hp_id` of `src_all`: 1 means clear the pending bit for all targets, 0 means clear it for this processor only.
- R5: A completion request made while `run_id` is 1023 has no effect. No strobe is raised, `busy` stays low and the running state is unchanged.
- R6: A completion takes its interrupt ID from `eoi_val[9:0]` only. Bits 31:10 have no effect.
- R7: Completing the ID equal to `run_id` makes its back-link the new `run_id` one cycle later. `run_prio` becomes that interrupt's entry in `src_prio`, or 0x100 when the back-link is 1023.
- R8: One cycle after an accepted completion of an ID below `NUM_IRQ`, `rep_valid` pulses with `rep_id` = that ID if the source is level-triggered (`src_edge` bit 0), enabled, has its level input high and targets this processor. Otherwise `rep_valid` stays low.
- R9: Completing an ID other than `run_id` walks the chain starting at `run_id`. `busy` is high for exactly k cycles, where k is the number of links read before reaching the link equal to the completed ID (which is then replaced by the completed ID's own back-link) or a link of 1023. `run_id` and `run_prio` do not change.
- R10: While `busy` is high, acknowledge and completion requests are ignored. No `ack_valid` follows, and the running state does not change.
- R11: When acknowledge and completion are requested in the same cycle, the completion is served and the acknowledge is dropped, so no `ack_valid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req | input | 1 | Acknowledge request, one cycle |
| hp_id | input | 10 | Highest pending interrupt ID from the selector |
| hp_prio | input | PRIO_W | Priority of `hp_id` |
| eoi_req | input | 1 | Completion request, one cycle |
| eoi_val | input | 32 | Completion value; ID in bits 9:0 |
| src_prio | input | NUM_IRQ x PRIO_W | Priority of each source |
| src_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| src_en | input | NUM_IRQ | Source enable |
| src_level | input | NUM_IRQ | Current input level of each source |
| src_to_me | input | NUM_IRQ | Source targets this processor |
| src_all | input | NUM_IRQ | 1 = one-of-N handling (clear for all targets) |
| ack_valid | output | 1 | Acknowledge answer strobe |
| ack_id | output | 10 | Acknowledged ID, 1023 if rejected |
| clr_valid | output | 1 | Pending-clear strobe |
| clr_id | output | 10 | ID whose pending state is cleared |
| clr_all | output | 1 | Clear for every target (1) or only this one (0) |
| rep_valid | output | 1 | Re-pend strobe for this processor |
| rep_id | output | 10 | ID to mark pending again |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| busy | output | 1 | Chain walk in progress |

## Verification
All answers to a request are registered once. `ack_valid`, `ack_id`, `clr_*`, `rep_*`, and the new `run_id` and `run_prio` after an acknowledge or a completion of the running interrupt, are due one cycle after the request edge. `busy` rises in that same cycle and stays high for exactly the link count of the walk. The bench drives each request on a falling edge, releases it on the next falling edge, samples the one-cycle results there, and then counts falling edges while `busy` is high, so the walk length is compared as a number. The running state is checked only after `busy` has dropped.

// File: rtl/nest_irq_pkg.sv
`timescale 1ns/1ps
package nest_irq_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] ID_NONE = '1;

  // A source is re-armed on completion only when it is level-sensitive,
  // enabled, still asserted and aimed at this processor.
  function automatic logic refire_ok(input logic edge_trig, input logic en,
                                     input logic lvl, input logic to_me);
    return !edge_trig && en && lvl && to_me;
  endfunction
endpackage

// File: rtl/nest_link_table.sv
`timescale 1ns/1ps
module nest_link_table
  import nest_irq_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [ID_W-1:0] w_idx,
  input  logic [ID_W-1:0] w_val,
  input  logic [ID_W-1:0] ra_idx,
  output logic [ID_W-1:0] ra_val,
  input  logic [ID_W-1:0] rb_idx,
  output logic [ID_W-1:0] rb_val
);
  localparam int IX_W = $clog2(NUM_IRQ);
  localparam logic [ID_W-1:0] LIM = ID_W'(NUM_IRQ);

  logic [ID_W-1:0] links [NUM_IRQ];

  function automatic logic in_range(input logic [ID_W-1:0] i);
    return i < LIM;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) links[i] <= ID_NONE;
    end else if (we && in_range(w_idx)) begin
      links[w_idx[IX_W-1:0]] <= w_val;
    end
  end

  assign ra_val = in_range(ra_idx) ? links[ra_idx[IX_W-1:0]] : ID_NONE;
  assign rb_val = in_range(rb_idx) ? links[rb_idx[IX_W-1:0]] : ID_NONE;

  // R3: a back-link is only ever written with an in-range ID or "none"
  a_r3_link_value_sane: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (w_val == ID_NONE || w_val < LIM));
endmodule

// File: rtl/nest_chain_walker.sv
`timescale 1ns/1ps
module nest_chain_walker
  import nest_irq_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] start_at,
  input  logic [ID_W-1:0] find_id,
  input  logic [ID_W-1:0] link_val,
  output logic            busy,
  output logic [ID_W-1:0] cursor,
  output logic [ID_W-1:0] find,
  output logic            splice_we
);
  localparam int STEP_W = $clog2(NUM_IRQ + 2) + 1;

  logic              hit;
  logic              chain_end;
  logic [STEP_W-1:0] steps;

  assign hit       = busy && (link_val == find) && (link_val != ID_NONE);
  assign chain_end = busy && (link_val == ID_NONE);
  assign splice_we = hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cursor <= ID_NONE;
      find   <= ID_NONE;
      steps  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cursor <= start_at;
      find   <= find_id;
      steps  <= '0;
    end else if (busy) begin
      steps <= steps + 1'b1;
      if (hit || chain_end) busy <= 1'b0;
      else                  cursor <= link_val;
    end
  end

  // R9: the walk always terminates within the number of sources
  a_r9_walk_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> steps < STEP_W'(NUM_IRQ));
  // R9: a splice ends the walk
  a_r9_splice_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    splice_we |=> !busy);
  // R10: no new walk can start on top of a running one
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/nest_run_ctrl.sv
`timescale 1ns/1ps
module nest_run_ctrl
  import nest_irq_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ack_req,
  input  logic [ID_W-1:0]                hp_id,
  input  logic [PRIO_W-1:0]              hp_prio,
  input  logic                           eoi_req,
  input  logic [ID_W-1:0]                eoi_id,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] src_prio,
  input  logic [NUM_IRQ-1:0]             src_edge,
  input  logic [NUM_IRQ-1:0]             src_en,
  input  logic [NUM_IRQ-1:0]             src_level,
  input  logic [NUM_IRQ-1:0]             src_to_me,
  input  logic [NUM_IRQ-1:0]             src_all,
  input  logic                           walk_busy,
  input  logic [ID_W-1:0]                link_run,
  output logic                           link_we,
  output logic [ID_W-1:0]                link_w_idx,
  output logic [ID_W-1:0]                link_w_val,
  output logic                           walk_start,
  output logic                           ack_valid,
  output logic [ID_W-1:0]                ack_id,
  output logic                           clr_valid,
  output logic [ID_W-1:0]                clr_id,
  output logic                           clr_all,
  output logic                           rep_valid,
  output logic [ID_W-1:0]                rep_id,
  output logic [ID_W-1:0]                run_id,
  output logic [PRIO_W:0]                run_prio
);
  localparam int IX_W = $clog2(NUM_IRQ);
  localparam logic [ID_W-1:0] LIM = ID_W'(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  function automatic logic [PRIO_W:0] prio_at(input logic [ID_W-1:0] i);
    if (i == ID_NONE || i >= LIM) return IDLE_PRIO;
    return {1'b0, src_prio[i[IX_W-1:0]]};
  endfunction

  logic            hp_in, eoi_in;
  logic [IX_W-1:0] hp_ix, eoi_ix;
  logic            ack_go, ack_ok, eoi_go, eoi_run, rearm;
  logic [PRIO_W:0] restore_prio;

  assign hp_in  = hp_id < LIM;
  assign hp_ix  = hp_id[IX_W-1:0];
  assign eoi_in = eoi_id < LIM;
  assign eoi_ix = eoi_id[IX_W-1:0];

  // completion wins over acknowledge; both stall behind a walk
  assign ack_go  = ack_req && !walk_busy && !eoi_req;
  assign ack_ok  = ack_go && hp_in && ({1'b0, hp_prio} < run_prio);
  assign eoi_go  = eoi_req && !walk_busy && (run_id != ID_NONE);
  assign eoi_run = eoi_go && (eoi_id == run_id);
  assign rearm   = eoi_go && eoi_in &&
                   refire_ok(src_edge[eoi_ix], src_en[eoi_ix],
                             src_level[eoi_ix], src_to_me[eoi_ix]);

  assign restore_prio = prio_at(link_run);
  assign walk_start   = eoi_go && !eoi_run;
  assign link_we      = ack_ok;
  assign link_w_idx   = hp_id;
  assign link_w_val   = run_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_id    <= ID_NONE;
      run_prio  <= IDLE_PRIO;
      ack_valid <= 1'b0;
      ack_id    <= ID_NONE;
      clr_valid <= 1'b0;
      clr_id    <= ID_NONE;
      clr_all   <= 1'b0;
      rep_valid <= 1'b0;
      rep_id    <= ID_NONE;
    end else begin
      ack_valid <= ack_go;
      ack_id    <= ack_ok ? hp_id : ID_NONE;
      clr_valid <= ack_ok;
      rep_valid <= rearm;
      if (ack_ok) begin
        clr_id   <= hp_id;
        clr_all  <= src_all[hp_ix];
        run_id   <= hp_id;
        run_prio <= {1'b0, hp_prio};
      end else if (eoi_run) begin
        run_id   <= link_run;
        run_prio <= restore_prio;
      end
      if (rearm) rep_id <= eoi_id;
    end
  end

  // R2: a refused acknowledge never clears pending state
  a_r2_reject_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id == ID_NONE) |-> !clr_valid);
  // R3: an accepted interrupt is the running one right away
  a_r3_ack_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id != ID_NONE) |-> (run_id == ack_id && clr_valid));
  // R7: idle ID and idle priority always travel together
  a_r7_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == ID_NONE) |-> (run_prio == IDLE_PRIO));
  // R5: completion with nothing running stays silent
  a_r5_idle_eoi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && run_id == ID_NONE && !walk_busy) |=> (!rep_valid && $stable(run_id)));
  // R9 / R10: running state frozen during a walk, and no answer to a request
  a_r9_run_stable_walk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |=> ($stable(run_id) && $stable(run_prio)));
  a_r10_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |=> !ack_valid);
  // R11: completion takes the cycle, acknowledge is dropped
  a_r11_eoi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && eoi_req) |=> !ack_valid);
endmodule

// File: rtl/nest_irq_tracker.sv
`timescale 1ns/1ps
module nest_irq_tracker
  import nest_irq_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ack_req,
  input  logic [9:0]                     hp_id,
  input  logic [PRIO_W-1:0]              hp_prio,
  input  logic                           eoi_req,
  input  logic [31:0]                    eoi_val,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] src_prio,
  input  logic [NUM_IRQ-1:0]             src_edge,
  input  logic [NUM_IRQ-1:0]             src_en,
  input  logic [NUM_IRQ-1:0]             src_level,
  input  logic [NUM_IRQ-1:0]             src_to_me,
  input  logic [NUM_IRQ-1:0]             src_all,
  output logic                           ack_valid,
  output logic [9:0]                     ack_id,
  output logic                           clr_valid,
  output logic [9:0]                     clr_id,
  output logic                           clr_all,
  output logic                           rep_valid,
  output logic [9:0]                     rep_id,
  output logic [9:0]                     run_id,
  output logic [PRIO_W:0]                run_prio,
  output logic                           busy
);
  logic [ID_W-1:0] eoi_id;
  logic            eoi_hi_unused;
  logic            walk_start, splice_we, ack_link_we;
  logic [ID_W-1:0] cursor, find, ack_w_idx, ack_w_val;
  logic [ID_W-1:0] ra_idx, ra_val, rb_val;
  logic            tab_we;
  logic [ID_W-1:0] tab_w_idx, tab_w_val;

  assign eoi_id        = eoi_val[ID_W-1:0];
  assign eoi_hi_unused = ^eoi_val[31:ID_W];

  // port A follows the walk cursor while busy, otherwise the running ID
  assign ra_idx    = busy ? cursor : run_id;
  assign tab_we    = splice_we | ack_link_we;
  assign tab_w_idx = splice_we ? cursor : ack_w_idx;
  assign tab_w_val = splice_we ? rb_val : ack_w_val;

  nest_link_table #(.NUM_IRQ(NUM_IRQ)) u_links (
    .clk(clk), .rst_n(rst_n),
    .we(tab_we), .w_idx(tab_w_idx), .w_val(tab_w_val),
    .ra_idx(ra_idx), .ra_val(ra_val),
    .rb_idx(find), .rb_val(rb_val)
  );

  nest_chain_walker #(.NUM_IRQ(NUM_IRQ)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(walk_start), .start_at(run_id), .find_id(eoi_id),
    .link_val(ra_val), .busy(busy), .cursor(cursor), .find(find),
    .splice_we(splice_we)
  );

  nest_run_ctrl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_run (
    .clk(clk), .rst_n(rst_n),
    .ack_req(ack_req), .hp_id(hp_id), .hp_prio(hp_prio),
    .eoi_req(eoi_req), .eoi_id(eoi_id),
    .src_prio(src_prio), .src_edge(src_edge), .src_en(src_en),
    .src_level(src_level), .src_to_me(src_to_me), .src_all(src_all),
    .walk_busy(busy), .link_run(ra_val),
    .link_we(ack_link_we), .link_w_idx(ack_w_idx), .link_w_val(ack_w_val),
    .walk_start(walk_start),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .clr_valid(clr_valid), .clr_id(clr_id), .clr_all(clr_all),
    .rep_valid(rep_valid), .rep_id(rep_id),
    .run_id(run_id), .run_prio(run_prio)
  );

  // R9: table writes from splice and acknowledge never collide
  a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(splice_we && ack_link_we));
endmodule

// File: tb/nest_irq_tracker_test.sv
`timescale 1ns/1ps
module nest_irq_tracker_test;
  localparam int N  = 64;
  localparam int PW = 8;
  localparam logic [9:0] NONE = 10'd1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack_req = 1'b0, eoi_req = 1'b0;
  logic [9:0] hp_id = '0;
  logic [PW-1:0] hp_prio = '0;
  logic [31:0] eoi_val = '0;
  logic [N-1:0][PW-1:0] src_prio;
  logic [N-1:0] src_edge = '0, src_en = '0, src_level = '0, src_to_me = '0, src_all = '0;
  logic ack_valid, clr_valid, clr_all, rep_valid, busy;
  logic [9:0] ack_id, clr_id, rep_id, run_id;
  logic [PW:0] run_prio;

  int total = 0, bad = 0;
  bit done = 0;

  logic c_ack_v, c_clr_v, c_clr_all, c_rep_v;
  logic [9:0] c_ack_id, c_clr_id, c_rep_id;
  int c_busy;

  always #2.5 clk = ~clk;

  nest_irq_tracker #(.NUM_IRQ(N), .PRIO_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .hp_id(hp_id), .hp_prio(hp_prio),
    .eoi_req(eoi_req), .eoi_val(eoi_val), .src_prio(src_prio), .src_edge(src_edge),
    .src_en(src_en), .src_level(src_level), .src_to_me(src_to_me), .src_all(src_all),
    .ack_valid(ack_valid), .ack_id(ack_id), .clr_valid(clr_valid), .clr_id(clr_id),
    .clr_all(clr_all), .rep_valid(rep_valid), .rep_id(rep_id), .run_id(run_id),
    .run_prio(run_prio), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one request for one cycle, capture the one-cycle answers, count busy cycles
  task automatic run_op(input logic is_ack, input logic [9:0] id, input logic [PW-1:0] pr,
                        input logic [31:0] hi);
    @(negedge clk);
    if (is_ack) begin ack_req = 1'b1; hp_id = id; hp_prio = pr; end
    else begin eoi_req = 1'b1; eoi_val = hi | {22'd0, id}; end
    @(negedge clk);
    ack_req = 1'b0; eoi_req = 1'b0;
    c_ack_v = ack_valid; c_ack_id = ack_id; c_clr_v = clr_valid; c_clr_id = clr_id;
    c_clr_all = clr_all; c_rep_v = rep_valid; c_rep_id = rep_id;
    c_busy = 0;
    while (busy && c_busy < 200) begin c_busy++; @(negedge clk); end
  endtask

  // row: op(1) id(10) prio(8) exp_ack(10) exp_run(10) exp_runprio(9) exp_busy(4)
  localparam int ROWS = 19;
  localparam logic [51:0] TAB [ROWS] = '{
    {1'b1, 10'd1023, 8'h00, 10'd1023, 10'd1023, 9'h100, 4'd0}, // R2 none offered
    {1'b1, 10'd5,    8'h80, 10'd5,    10'd5,    9'h080, 4'd0}, // R3
    {1'b1, 10'd7,    8'h80, 10'd1023, 10'd5,    9'h080, 4'd0}, // R2 equal prio
    {1'b1, 10'd7,    8'h40, 10'd7,    10'd7,    9'h040, 4'd0}, // R3
    {1'b1, 10'd9,    8'h20, 10'd9,    10'd9,    9'h020, 4'd0}, // R3
    {1'b0, 10'd7,    8'h00, 10'd1023, 10'd9,    9'h020, 4'd1}, // R9 splice depth 1
    {1'b0, 10'd9,    8'h00, 10'd1023, 10'd5,    9'h080, 4'd0}, // R7 via spliced link
    {1'b0, 10'd5,    8'h00, 10'd1023, 10'd1023, 9'h100, 4'd0}, // R7 back to idle
    {1'b1, 10'd5,    8'h80, 10'd5,    10'd5,    9'h080, 4'd0},
    {1'b1, 10'd7,    8'h40, 10'd7,    10'd7,    9'h040, 4'd0},
    {1'b1, 10'd9,    8'h20, 10'd9,    10'd9,    9'h020, 4'd0},
    {1'b1, 10'd11,   8'h10, 10'd11,   10'd11,   9'h010, 4'd0},
    {1'b0, 10'd5,    8'h00, 10'd1023, 10'd11,   9'h010, 4'd3}, // R9 splice depth 3
    {1'b0, 10'd11,   8'h00, 10'd1023, 10'd9,    9'h020, 4'd0}, // R7
    {1'b0, 10'd20,   8'h00, 10'd1023, 10'd9,    9'h020, 4'd2}, // R9 not in chain
    {1'b0, 10'd9,    8'h00, 10'd1023, 10'd7,    9'h040, 4'd0}, // R7
    {1'b0, 10'd7,    8'h00, 10'd1023, 10'd1023, 9'h100, 4'd0}, // R7 tail was spliced
    {1'b0, 10'd7,    8'h00, 10'd1023, 10'd1023, 9'h100, 4'd0}, // R5 idle completion
    {1'b1, 10'd100,  8'h00, 10'd1023, 10'd1023, 9'h100, 4'd0}  // R2 out of range
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < N; i++) src_prio[i] = 8'hF0;
    src_prio[5] = 8'h80; src_prio[7] = 8'h40; src_prio[9] = 8'h20; src_prio[11] = 8'h10;
    src_all[5] = 1'b1; src_all[11] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 run_id", run_id, NONE);
    check("R1 run_prio", run_prio, 9'h100);
    check("R1 busy", busy, 0);
    check("R1 strobes", {ack_valid, clr_valid, rep_valid}, 0);

    for (int r = 0; r < ROWS; r++) begin
      logic op; logic [9:0] id, e_ack, e_run; logic [7:0] pr; logic [8:0] e_rp; logic [3:0] e_b;
      {op, id, pr, e_ack, e_run, e_rp, e_b} = TAB[r];
      run_op(op, id, pr, 32'd0);
      if (op) begin
        check($sformatf("R2/R3 row%0d ack_valid", r), c_ack_v, 1);
        check($sformatf("R2/R3 row%0d ack_id", r), c_ack_id, e_ack);
        check($sformatf("R4 row%0d clr_valid", r), c_clr_v, e_ack != NONE);
        if (e_ack != NONE) begin
          check($sformatf("R4 row%0d clr_id", r), c_clr_id, id);
          check($sformatf("R4 row%0d clr_all", r), c_clr_all, src_all[id[5:0]]);
        end
      end else begin
        check($sformatf("R5/R7 row%0d no ack", r), c_ack_v, 0);
      end
      check($sformatf("R8 row%0d no rep (sources disabled)", r), c_rep_v, 0);
      check($sformatf("R9 row%0d busy cycles", r), c_busy, e_b);
      check($sformatf("R7/R9 row%0d run_id", r), run_id, e_run);
      check($sformatf("R7/R9 row%0d run_prio", r), run_prio, e_rp);
    end

    // R8: level source, enabled, high, aimed here -> re-pend
    src_en[5] = 1'b1; src_level[5] = 1'b1; src_to_me[5] = 1'b1; src_edge[5] = 1'b0;
    run_op(1'b1, 10'd5, 8'h80, 0);
    run_op(1'b0, 10'd5, 8'h00, 0);
    check("R8 rep_valid level source", c_rep_v, 1);
    check("R8 rep_id", c_rep_id, 10'd5);
    // R8: edge source -> no re-pend
    src_edge[5] = 1'b1;
    run_op(1'b1, 10'd5, 8'h80, 0);
    run_op(1'b0, 10'd5, 8'h00, 0);
    check("R8 edge source no rep", c_rep_v, 0);
    // R8: not aimed here -> no re-pend
    src_edge[5] = 1'b0; src_to_me[5] = 1'b0;
    run_op(1'b1, 10'd5, 8'h80, 0);
    run_op(1'b0, 10'd5, 8'h00, 0);
    check("R8 other target no rep", c_rep_v, 0);

    // R6: upper bits of completion value ignored
    run_op(1'b1, 10'd5, 8'h80, 0);
    run_op(1'b0, 10'd5, 8'h00, 32'hFFFF_FC00);
    check("R6 run_id after high-bit completion", run_id, NONE);
    check("R6 run_prio", run_prio, 9'h100);

    // R10: requests ignored while walking
    run_op(1'b1, 10'd5, 8'h80, 0);
    run_op(1'b1, 10'd7, 8'h40, 0);
    run_op(1'b1, 10'd9, 8'h20, 0);
    run_op(1'b1, 10'd11, 8'h10, 0);
    @(negedge clk);
    eoi_req = 1'b1; eoi_val = 32'd5;
    @(negedge clk);
    eoi_req = 1'b0;
    check("R10 busy during walk", busy, 1);
    ack_req = 1'b1; hp_id = 10'd13; hp_prio = 8'h01;
    @(negedge clk);
    ack_req = 1'b0;
    check("R10 no ack while busy", ack_valid, 0);
    for (int k = 0; k < 10 && busy; k++) @(negedge clk);
    check("R10 run_id unchanged", run_id, 10'd11);
    run_op(1'b0, 10'd11, 8'h00, 0);
    run_op(1'b0, 10'd9, 8'h00, 0);
    run_op(1'b0, 10'd7, 8'h00, 0);
    check("R9 spliced chain reaches idle", run_id, NONE);

    // R11: simultaneous acknowledge and completion
    run_op(1'b1, 10'd7, 8'h40, 0);
    @(negedge clk);
    ack_req = 1'b1; hp_id = 10'd9; hp_prio = 8'h20;
    eoi_req = 1'b1; eoi_val = 32'd7;
    @(negedge clk);
    ack_req = 1'b0; eoi_req = 1'b0;
    check("R11 ack dropped", ack_valid, 0);
    check("R11 completion served", run_id, NONE);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule